// File: doc/BRIEF.md
# Processor Bus Low-Power Link Controller

This block sits on the host side of a point-to-point processor system bus and decides when that bus may be taken down so the processor can run on a reduced clock. It watches decoded Halt and Stop Grant special cycles. If the matching enable bit is set, it lowers the link once no snoop probes remain outstanding. It raises the link again for one of two reasons. A wake event returns the bus to normal operation. A probe that arrives while the link is down causes a short reconnect, and the link then drops again by itself as soon as the probe has been serviced.

The link is driven through two registered sideband outputs, a connect request and a clock-forward reset. The processor answers each step on a ready input. If that answer does not come within a programmable number of cycles, the controller raises a sticky error and freezes in place until reset.

Top module: `lpbus_link_ctrl`

## Requirements
- R1: While reset is asserted, and in the first cycle after it is released, the state code is 0 (Linked), `link_conn_o` is 1, `link_fwdrst_o` is 0 and `tmo_err_o` is 0.
- R2: A pulse on `cfg_wr` loads `cfg_wdata`. Bit 0 enables disconnect on Halt and bit 1 enables disconnect on Stop Grant. A special cycle whose enable bit is clear leaves the state at Linked (0) with `link_conn_o` at 1.
- R3: In Linked, a special cycle whose enable bit is set moves the state to Drain (1) on the next edge. Special cycles seen in any other state are ignored.
- R4: `probe_req` adds one outstanding probe and `probe_done` removes one. In Drain, the state holds with `link_conn_o` at 1 for as long as any probe is outstanding or a new request is present.
- R5: The disconnect follows a fixed order. First `link_conn_o` falls (Release, code 2). Once the synchronised ready input reads 0, `link_fwdrst_o` rises (Parked, code 3). `link_fwdrst_o` never rises while `link_conn_o` was 1 in the previous cycle.
- R6: A `wake_i` pulse in Parked starts a reconnect. The controller spends one cycle in Rejoin A (code 4) with both outputs at 1, then moves to Rejoin B (code 5) with `link_fwdrst_o` at 0. It waits there for ready at 1 and then enters Linked.
- R7: A probe request in Parked, or an outstanding probe, triggers the same reconnect. The controller then goes to Drain instead of Linked and returns to Parked once the probes have completed, with no new special cycle needed.
- R8: A `wake_i` pulse during Drain, or during a probe-triggered reconnect, cancels the pending disconnect and leaves the controller in Linked.
- R9: In Release or Rejoin B, if ready has not reached the level being waited for within `cfg_tmo` cycles, `tmo_err_o` goes to 1. The state and both outputs then stay frozen until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr | input | 1 | Write strobe for the enable register |
| cfg_wdata | input | 2 | Enable bits: [0] Halt, [1] Stop Grant |
| cfg_tmo | input | TMO_W | Ready timeout limit in cycles |
| halt_cyc | input | 1 | Decoded Halt special cycle (pulse) |
| stpgnt_cyc | input | 1 | Decoded Stop Grant special cycle (pulse) |
| probe_req | input | 1 | New snoop probe to be serviced (pulse) |
| probe_done | input | 1 | One snoop probe completed (pulse) |
| wake_i | input | 1 | Wake event: interrupt or stop-clock release (pulse) |
| proc_rdy_i | input | 1 | Processor readiness acknowledge |
| link_conn_o | output | 1 | Registered connect request to the processor |
| link_fwdrst_o | output | 1 | Registered clock-forward reset to the processor |
| state_o | output | 3 | Current state code (0..5) |
| tmo_err_o | output | 1 | Sticky ready-timeout error |

## Verification
The bound checker looks at every cycle for violations of the sideband ordering. It catches the forward reset rising while connect was high, connect dropping while probes are outstanding, reconnect not starting with connect high and forward reset still held, and Linked being entered from Rejoin B without ready. It also checks that a disabled special cycle never leaves Linked and that the state stays frozen once the timeout error is set. Only the bench scenarios can show the end-to-end sequences. These are the drain wait lasting as long as the probe traffic, the automatic second disconnect after a probe-triggered reconnect, a wake cancelling a pending disconnect, and the cycle at which the timeout fires against a processor that has stopped answering.

// File: rtl/lpbus_pkg.sv
package lpbus_pkg;
   typedef enum logic [2:0] {
      ST_LINKED  = 3'd0,
      ST_DRAIN   = 3'd1,
      ST_RELEASE = 3'd2,
      ST_PARKED  = 3'd3,
      ST_REJOIN_A = 3'd4,
      ST_REJOIN_B = 3'd5
   } link_st_e;

   localparam int CFG_BITS = 2;
   localparam int CFG_HALT_BIT = 0;
   localparam int CFG_STOP_BIT = 1;
endpackage

// File: rtl/lpbus_probe_track.sv
module lpbus_probe_track #(
   parameter int PEND_W = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_i,
   input  logic              done_i,
   output logic [PEND_W-1:0] pend_o,
   output logic              idle_o
);
   localparam logic [PEND_W-1:0] PEND_MAX = {PEND_W{1'b1}};

   logic [PEND_W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else begin
         if (req_i && !done_i && cnt_q != PEND_MAX) begin
            cnt_q <= cnt_q + 1'b1;
         end else if (done_i && !req_i && cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
         end
      end
   end

   assign pend_o = cnt_q;
   // idle means nothing is outstanding and nothing new arrives this cycle
   assign idle_o = (cnt_q == '0) && !req_i;
endmodule

// File: rtl/lpbus_rdy_sync.sv
module lpbus_rdy_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d_i,
   output logic q_o
);
   generate
      if (STAGES == 0) begin : g_direct
         assign q_o = d_i;
      end else begin : g_chain
         logic [STAGES-1:0] sh_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               sh_q <= '0;
            end else begin
               for (int i = STAGES-1; i > 0; i--) begin
                  sh_q[i] <= sh_q[i-1];
               end
               sh_q[0] <= d_i;
            end
         end
         assign q_o = sh_q[STAGES-1];
      end
   endgenerate
endmodule

// File: rtl/lpbus_rdy_timer.sv
module lpbus_rdy_timer #(
   parameter int TMO_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             waiting_i,
   input  logic [TMO_W-1:0] limit_i,
   output logic             err_o
);
   logic [TMO_W-1:0] cnt_q;
   logic             err_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
         err_q <= 1'b0;
      end else if (!err_q) begin
         if (!waiting_i) begin
            cnt_q <= '0;
         end else if (cnt_q == limit_i) begin
            err_q <= 1'b1;
         end else begin
            cnt_q <= cnt_q + 1'b1;
         end
      end
   end

   assign err_o = err_q;
endmodule

// File: rtl/lpbus_link_ctrl.sv
module lpbus_link_ctrl
   import lpbus_pkg::*;
#(
   parameter int PEND_W   = 4,
   parameter int TMO_W    = 8,
   parameter int RDY_SYNC = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cfg_wr,
   input  logic [1:0]       cfg_wdata,
   input  logic [TMO_W-1:0] cfg_tmo,
   input  logic             halt_cyc,
   input  logic             stpgnt_cyc,
   input  logic             probe_req,
   input  logic             probe_done,
   input  logic             wake_i,
   input  logic             proc_rdy_i,
   output logic             link_conn_o,
   output logic             link_fwdrst_o,
   output logic [2:0]       state_o,
   output logic             tmo_err_o
);
   generate
      if (PEND_W < 1) begin : g_bad_pend
         $error("PEND_W must be at least 1");
      end
      if (TMO_W < 2) begin : g_bad_tmo
         $error("TMO_W must be at least 2");
      end
      if (RDY_SYNC < 0 || RDY_SYNC > 4) begin : g_bad_sync
         $error("RDY_SYNC must be in 0..4");
      end
   endgenerate

   logic              halt_en_q, stop_en_q;
   logic [PEND_W-1:0] pend_cnt;
   logic              probes_idle;
   logic              rdy_s;
   logic              waiting;
   logic              err;
   link_st_e          st_q, st_d;
   logic              auto_q, auto_d;
   logic              conn_q, fwdrst_q;
   logic              conn_d, fwdrst_d;
   logic              trig;

   // enable register
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         halt_en_q <= 1'b0;
         stop_en_q <= 1'b0;
      end else if (cfg_wr) begin
         halt_en_q <= cfg_wdata[CFG_HALT_BIT];
         stop_en_q <= cfg_wdata[CFG_STOP_BIT];
      end
   end

   lpbus_probe_track #(.PEND_W(PEND_W)) u_trk (
      .clk(clk), .rst_n(rst_n), .req_i(probe_req), .done_i(probe_done),
      .pend_o(pend_cnt), .idle_o(probes_idle)
   );

   lpbus_rdy_sync #(.STAGES(RDY_SYNC)) u_sync (
      .clk(clk), .rst_n(rst_n), .d_i(proc_rdy_i), .q_o(rdy_s)
   );

   assign waiting = (st_q == ST_RELEASE && rdy_s) ||
                    (st_q == ST_REJOIN_B && !rdy_s);

   lpbus_rdy_timer #(.TMO_W(TMO_W)) u_tmr (
      .clk(clk), .rst_n(rst_n), .waiting_i(waiting), .limit_i(cfg_tmo),
      .err_o(err)
   );

   assign trig = (halt_cyc && halt_en_q) || (stpgnt_cyc && stop_en_q);

   always_comb begin
      st_d   = st_q;
      auto_d = auto_q;
      if (!err) begin
         unique case (st_q)
            ST_LINKED: begin
               auto_d = 1'b0;
               if (trig) st_d = ST_DRAIN;
            end
            ST_DRAIN: begin
               if (wake_i) begin
                  st_d   = ST_LINKED;
                  auto_d = 1'b0;
               end else if (probes_idle) begin
                  st_d   = ST_RELEASE;
                  auto_d = 1'b0;
               end
            end
            ST_RELEASE: begin
               if (!rdy_s) st_d = ST_PARKED;
            end
            ST_PARKED: begin
               if (probe_req || pend_cnt != '0) begin
                  st_d   = ST_REJOIN_A;
                  auto_d = !wake_i;
               end else if (wake_i) begin
                  st_d   = ST_REJOIN_A;
                  auto_d = 1'b0;
               end
            end
            ST_REJOIN_A: begin
               st_d = ST_REJOIN_B;
               if (wake_i) auto_d = 1'b0;
            end
            ST_REJOIN_B: begin
               if (wake_i) auto_d = 1'b0;
               if (rdy_s) st_d = (auto_q && !wake_i) ? ST_DRAIN : ST_LINKED;
            end
            default: st_d = ST_LINKED;
         endcase
      end
   end

   // sideband levels taken from the next state so the pins move with the state register
   always_comb begin
      unique case (st_d)
         ST_RELEASE:  begin conn_d = 1'b0; fwdrst_d = 1'b0; end
         ST_PARKED:   begin conn_d = 1'b0; fwdrst_d = 1'b1; end
         ST_REJOIN_A: begin conn_d = 1'b1; fwdrst_d = 1'b1; end
         default:     begin conn_d = 1'b1; fwdrst_d = 1'b0; end
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q     <= ST_LINKED;
         auto_q   <= 1'b0;
         conn_q   <= 1'b1;
         fwdrst_q <= 1'b0;
      end else begin
         st_q     <= st_d;
         auto_q   <= auto_d;
         conn_q   <= conn_d;
         fwdrst_q <= fwdrst_d;
      end
   end

   assign link_conn_o   = conn_q;
   assign link_fwdrst_o = fwdrst_q;
   assign state_o       = st_q;
   assign tmo_err_o     = err;
endmodule

// File: rtl/lpbus_link_chk.sv
module lpbus_link_chk #(
   parameter int PEND_W = 4
) (
   input logic              clk,
   input logic              rst_n,
   input logic              link_conn_o,
   input logic              link_fwdrst_o,
   input logic [2:0]        state_o,
   input logic              tmo_err_o,
   input logic              halt_cyc,
   input logic              stpgnt_cyc,
   input logic              halt_en_q,
   input logic              stop_en_q,
   input logic              rdy_s,
   input logic [PEND_W-1:0] pend_cnt
);
   // R1: the Linked state always presents a connected link
   assert_linked_pins_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (state_o == 3'd0) |-> (link_conn_o && !link_fwdrst_o));

   // R2: a special cycle whose enable bit is clear keeps the link up
   assert_disabled_stays_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (state_o == 3'd0 && !(halt_cyc && halt_en_q) && !(stpgnt_cyc && stop_en_q))
      |=> (state_o == 3'd0));

   // R4: connect only drops once the probe tracker has drained
   assert_drop_drained_R4: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(link_conn_o) |-> ($past(pend_cnt) == '0));

   // R5: forward reset only rises once connect was already low
   assert_fwdrst_after_conn_R5: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(link_fwdrst_o) |-> !$past(link_conn_o));

   // R6: reconnect raises connect while forward reset is still held
   assert_rejoin_order_R6: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(link_conn_o) |-> link_fwdrst_o);

   // R6: forward reset is released only with connect high
   assert_release_connected_R6: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(link_fwdrst_o) |-> link_conn_o);

   // R6: Linked is entered from Rejoin B only after ready was seen
   assert_rejoin_needs_rdy_R6: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(state_o) == 3'd5 && state_o != 3'd5) |-> $past(rdy_s));

   // R9: once the timeout error is set, state and pins freeze
   assert_err_freeze_R9: assert property (@(posedge clk) disable iff (!rst_n)
      $past(tmo_err_o) |-> ($stable(state_o) && $stable(link_conn_o) && $stable(link_fwdrst_o) && tmo_err_o));
endmodule

bind lpbus_link_ctrl lpbus_link_chk #(.PEND_W(PEND_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .link_conn_o(link_conn_o), .link_fwdrst_o(link_fwdrst_o),
   .state_o(state_o), .tmo_err_o(tmo_err_o), .halt_cyc(halt_cyc), .stpgnt_cyc(stpgnt_cyc),
   .halt_en_q(halt_en_q), .stop_en_q(stop_en_q), .rdy_s(rdy_s), .pend_cnt(pend_cnt)
);

// File: tb/sim_lpbus_link_ctrl.sv
`timescale 1ns/1ps
module sim_lpbus_link_ctrl;
   localparam int TMO_W = 8;
   localparam int TMO   = 20;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic cfg_wr = 0;
   logic [1:0] cfg_wdata = 0;
   logic [TMO_W-1:0] cfg_tmo = TMO[TMO_W-1:0];
   logic halt_cyc = 0, stpgnt_cyc = 0, probe_req = 0, probe_done = 0, wake_i = 0;
   logic proc_rdy;
   logic link_conn, link_fwdrst, tmo_err;
   logic [2:0] state;

   int n_chk = 0, n_fail = 0;
   logic proc_dead = 0;
   logic [2:0] rdy_pipe;
   logic prev_conn;
   int order_bad = 0;
   logic seen_a = 0;
   logic a_before_b_bad = 0;

   always #2 clk = ~clk;

   lpbus_link_ctrl #(.TMO_W(TMO_W)) u0 (
      .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_wdata(cfg_wdata), .cfg_tmo(cfg_tmo),
      .halt_cyc(halt_cyc), .stpgnt_cyc(stpgnt_cyc), .probe_req(probe_req),
      .probe_done(probe_done), .wake_i(wake_i), .proc_rdy_i(proc_rdy),
      .link_conn_o(link_conn), .link_fwdrst_o(link_fwdrst), .state_o(state),
      .tmo_err_o(tmo_err)
   );

   // simple processor model: ready follows "connected and not in forward reset" after 3 cycles
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) rdy_pipe <= 3'b111;
      else if (!proc_dead) rdy_pipe <= {rdy_pipe[1:0], link_conn & ~link_fwdrst};
   end
   assign proc_rdy = rdy_pipe[2];

   // ordering monitor sampled away from the active edge
   always @(negedge clk) begin
      if (rst_n) begin
         if (link_fwdrst && !prev_rst_fw && prev_conn) order_bad++;
         if (state == 3'd4) seen_a = 1;
         if (state == 3'd5 && !seen_a) a_before_b_bad = 1;
         if (state == 3'd0) seen_a = 0;
      end
      prev_conn = link_conn;
      prev_rst_fw = link_fwdrst;
   end
   logic prev_rst_fw = 0;

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic cyc(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   task automatic pulse(ref logic s);
      s = 1; cyc(1); s = 0;
   endtask

   task automatic wait_st(input logic [2:0] tgt, input int maxc, output int took);
      took = -1;
      for (int i = 0; i < maxc; i++) begin
         if (state == tgt) begin took = i; break; end
         cyc(1);
      end
   endtask

   task automatic do_reset();
      rst_n = 0; proc_dead = 0; cyc(3);
      check("R1 state in reset", state, 0);
      check("R1 conn in reset", link_conn, 1);
      rst_n = 1; cyc(1);
      check("R1 state after reset", state, 0);
      check("R1 conn after reset", link_conn, 1);
      check("R1 fwdrst after reset", link_fwdrst, 0);
      check("R1 err after reset", tmo_err, 0);
   endtask

   task automatic write_en(input logic [1:0] v);
      cfg_wdata = v; pulse(cfg_wr);
   endtask

   task automatic t_disabled();
      write_en(2'b10); // stop grant only
      pulse(halt_cyc); cyc(5);
      check("R2 halt disabled stays linked", state, 0);
      check("R2 halt disabled conn high", link_conn, 1);
      write_en(2'b00);
      pulse(stpgnt_cyc); cyc(5);
      check("R2 stop disabled stays linked", state, 0);
   endtask

   task automatic t_halt_park_wake();
      int t;
      write_en(2'b01);
      halt_cyc = 1; cyc(1); halt_cyc = 0;
      check("R3 enabled halt moves to drain or beyond", (state != 0), 1);
      wait_st(3'd3, 40, t);
      check("R5 reached parked", (t >= 0), 1);
      check("R5 parked conn low", link_conn, 0);
      check("R5 parked fwdrst high", link_fwdrst, 1);
      check("R5 fwdrst never rose with conn high", order_bad, 0);
      pulse(stpgnt_cyc); cyc(3);
      check("R3 special cycle ignored while parked", state, 3);
      pulse(wake_i);
      check("R6 rejoin A state", state, 4);
      check("R6 rejoin A both high", {link_conn, link_fwdrst}, 2'b11);
      cyc(1);
      check("R6 rejoin B state", state, 5);
      check("R6 rejoin B fwdrst low", link_fwdrst, 0);
      wait_st(3'd0, 40, t);
      check("R6 back to linked", (t >= 0), 1);
      check("R6 A precedes B", a_before_b_bad, 0);
      cyc(10);
      check("R6 stays linked after wake", state, 0);
   endtask

   task automatic t_drain_wait();
      int t;
      write_en(2'b10);
      pulse(probe_req); pulse(probe_req);
      pulse(stpgnt_cyc);
      cyc(15);
      check("R4 held in drain with probes out", state, 1);
      check("R4 conn high while draining", link_conn, 1);
      pulse(probe_done); cyc(4);
      check("R4 still draining with one probe", state, 1);
      pulse(probe_done);
      wait_st(3'd3, 40, t);
      check("R4 parks after drain", (t >= 0), 1);
   endtask

   task automatic t_probe_while_parked();
      int t;
      pulse(probe_req);
      check("R7 probe starts rejoin", state, 4);
      wait_st(3'd1, 40, t);
      check("R7 reaches drain after rejoin", (t >= 0), 1);
      check("R7 conn high for probe", link_conn, 1);
      cyc(5);
      check("R7 drain holds until probe done", state, 1);
      pulse(probe_done);
      wait_st(3'd3, 40, t);
      check("R7 automatic second disconnect", (t >= 0), 1);
   endtask

   task automatic t_wake_cancel();
      int t;
      pulse(probe_req);
      wait_st(3'd1, 40, t);
      pulse(wake_i);
      check("R8 wake in drain returns to linked", state, 0);
      pulse(probe_done); cyc(10);
      check("R8 no disconnect after cancel", state, 0);
      check("R8 conn high after cancel", link_conn, 1);
   endtask

   task automatic t_timeout();
      int t;
      int n;
      write_en(2'b01);
      proc_dead = 1;
      pulse(halt_cyc);
      wait_st(3'd2, 10, t);
      check("R9 in release", state, 2);
      n = 0;
      while (!tmo_err && n < 200) begin cyc(1); n++; end
      check("R9 error not early", (n >= TMO - 2), 1);
      check("R9 error raised in time", (n <= TMO + 4), 1);
      cyc(10);
      check("R9 state frozen", state, 2);
      check("R9 conn frozen", link_conn, 0);
      check("R9 err sticky", tmo_err, 1);
      pulse(wake_i); cyc(3);
      check("R9 wake ignored after error", state, 2);
      do_reset();
   endtask

   initial begin : watchdog
      #(4 * 100000);
      n_fail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      do_reset();
      t_disabled();
      t_halt_park_wake();
      t_drain_wait();
      t_probe_while_parked();
      t_wake_cancel();
      t_timeout();
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule